// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block compares the running calendar time of a real-time clock against a set of alarm digit registers and raises a sticky alarm flag when they agree. The time arrives as packed BCD digits. A once-per-second strobe decides when a comparison is taken. The alarm digits are loaded through a narrow nibble-wide write port that decodes a small register window. Any of the five compared fields can be excluded from the comparison. When a field is excluded, it matches whatever the current time holds.

Software programs the alarm digits and the control nibble, which holds the interrupt enable and the flag. After it services an alarm, software clears the flag by writing the control nibble. The interrupt output is a level that stays active for as long as both the flag and the enable are set. Month and year are not inputs to the block, so they never affect a match.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm flag, the interrupt enable and the interrupt output are all 0.
- R2: Writes to the register addresses below land in the alarm digits. Address 0 is seconds units and 1 is seconds tens. Address 2 is minutes units and 3 is minutes tens. Address 4 is hours units and 5 is hours tens. Address 6 is day of week. Address 7 is day-of-month units and 8 is day-of-month tens. Address 14 is the control nibble. A write to 9 to 13 or to 15 changes neither the alarm digits nor the control state.
- R3: Bit 3 of addresses 1, 3, 5, 6 and 8 excludes that field from the comparison. An excluded field matches any current value, and its units digit is excluded along with it.
- R4: The flag is set only on an evaluation strobe where every field matches and the previous strobe did not match. It is visible in the cycle after that strobe. A match that persists over consecutive strobes sets it once.
- R5: Once set, the flag stays set until a control write has bit 1 equal to 0. A control write with bit 1 equal to 1 leaves the flag unchanged.
- R6: Bit 0 of the control nibble is the interrupt enable. The interrupt output is high exactly while both the flag and the enable are 1.
- R7: If a flag-setting strobe and a flag-clearing control write occur in the same cycle, the flag ends up set.
- R8: A non-excluded field blocks the flag when it differs. Tens digits compare their low three bits against the current tens digit. Day of week compares its low three bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curDigits | input | 36 | Current time, nibble i holds the digit for register address i (0 to 8) |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write address |
| wrData | input | 4 | Register write data |
| evalTick | input | 1 | One-cycle strobe that takes a comparison |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqEnable | output | 1 | Current interrupt enable bit |
| alarmIrq | output | 1 | Level interrupt, flag AND enable |

## Verification
The bench builds the block with its default parameters: 4-bit digits, a 4-bit address and nine digit registers. This is the full BCD layout, so every field, every exclusion bit and every unused address in the window can be reached. Directed scenarios cover the following cases:
- a persistent match that must not set the flag twice;
- a strobe that coincides with a clearing write;
- writes to unmapped addresses, which must leave both the comparison and the enable intact.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int DIGIT_REGS = 9;
  localparam int CTRL_ADDR  = 14;

  typedef struct packed {
    logic [DIGIT_REGS-1:0] digitWr;
  } matchStrobes_t;
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  matchStrobes_t                  strobes,
  input  logic [DIGIT_W-1:0]             wrData,
  input  logic [DIGIT_REGS*DIGIT_W-1:0]  curDigits,
  output logic                           allMatch
);
  localparam int IGN = DIGIT_W - 1;
  localparam int TWO_DIGIT_FIELDS = 4;
  localparam int DOW_ADDR = 6;

  logic [DIGIT_W-1:0] alarmReg [DIGIT_REGS];
  logic [TWO_DIGIT_FIELDS:0] fieldOk;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DIGIT_REGS; i++) begin
      if (!rstN) alarmReg[i] <= '0;
      else if (strobes.digitWr[i]) alarmReg[i] <= wrData;
    end
  end

  for (genvar f = 0; f < TWO_DIGIT_FIELDS; f++) begin : g_field
    localparam int BASE = (f == TWO_DIGIT_FIELDS - 1) ? 7 : 2 * f;
    logic [DIGIT_W-1:0] onesReg, tensReg, curOnes, curTens;
    assign onesReg = alarmReg[BASE];
    assign tensReg = alarmReg[BASE+1];
    assign curOnes = curDigits[BASE*DIGIT_W +: DIGIT_W];
    assign curTens = curDigits[(BASE+1)*DIGIT_W +: DIGIT_W];
    assign fieldOk[f] = tensReg[IGN] |
                        ((onesReg == curOnes) && ({1'b0, tensReg[IGN-1:0]} == curTens));
  end

  logic [DIGIT_W-1:0] dowReg, curDow;
  assign dowReg = alarmReg[DOW_ADDR];
  assign curDow = curDigits[DOW_ADDR*DIGIT_W +: DIGIT_W];
  assign fieldOk[TWO_DIGIT_FIELDS] = dowReg[IGN] | ({1'b0, dowReg[IGN-1:0]} == curDow);

  assign allMatch = &fieldOk;
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        ctrlBits,
  input  logic              evalTick,
  input  logic              allMatch,
  output matchStrobes_t     strobes,
  output logic              alarmFlag,
  output logic              irqEnable,
  output logic              alarmIrq
);
  logic ctrlWr;
  logic matchPrev;
  logic riseHit;

  for (genvar i = 0; i < DIGIT_REGS; i++) begin : g_dec
    assign strobes.digitWr[i] = wrEn && (wrAddr == ADDR_W'(i));
  end
  assign ctrlWr  = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign riseHit = evalTick && allMatch && !matchPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      irqEnable <= 1'b0;
      matchPrev <= 1'b0;
    end else begin
      if (evalTick) matchPrev <= allMatch;
      if (ctrlWr) irqEnable <= ctrlBits[0];
      if (riseHit) alarmFlag <= 1'b1;
      else if (ctrlWr && !ctrlBits[1]) alarmFlag <= 1'b0;
    end
  end

  assign alarmIrq = alarmFlag & irqEnable;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alarm_match_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIGIT_REGS*DIGIT_W-1:0] curDigits,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DIGIT_W-1:0]            wrData,
  input  logic                          evalTick,
  output logic                          alarmFlag,
  output logic                          irqEnable,
  output logic                          alarmIrq
);
  matchStrobes_t strobes;
  logic allMatch;

  alarm_match_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctrlBits(wrData[1:0]), .evalTick(evalTick), .allMatch(allMatch),
    .strobes(strobes), .alarmFlag(alarmFlag), .irqEnable(irqEnable),
    .alarmIrq(alarmIrq)
  );

  alarm_match_dp #(.DIGIT_W(DIGIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .curDigits(curDigits), .allMatch(allMatch)
  );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import alarm_match_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DIGIT_W-1:0] wrData,
  input logic               evalTick,
  input logic               alarmFlag,
  input logic               irqEnable,
  input logic               alarmIrq
);
  logic ctrlHit;
  assign ctrlHit = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  p_flag_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !alarmFlag && !evalTick |=> !alarmFlag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag && !ctrlHit |=> alarmFlag);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit && !wrData[1] && !evalTick |=> !alarmFlag);

  p_enable_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> irqEnable == $past(wrData[0]));

  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlHit |=> $stable(irqEnable));

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq && !ctrlHit |=> alarmIrq);

  always_comb begin
    if (rstN && alarmIrq) begin
      a_irq_implies_flag_r6: assert (alarmFlag && irqEnable);
    end
  end
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.DIGIT_W(DIGIT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [35:0] curDigits = '0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic evalTick = 1'b0;
  logic alarmFlag, irqEnable, alarmIrq;
  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 4'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input int h, input int m, input int s, input int w, input int d);
    curDigits = {4'(d/10), 4'(d%10), 4'(w), 4'(h/10), 4'(h%10),
                 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10)};
  endtask

  task automatic tick();
    @(negedge clk);
    evalTick = 1'b1;
    @(negedge clk);
    evalTick = 1'b0;
  endtask

  // ignMask bit0 sec, bit1 min, bit2 hour, bit3 dow, bit4 day
  task automatic progAlarm(input int h, input int m, input int s, input int w,
                           input int d, input logic [4:0] ignMask);
    regWrite(0, s%10); regWrite(1, (s/10) | (ignMask[0] ? 8 : 0));
    regWrite(2, m%10); regWrite(3, (m/10) | (ignMask[1] ? 8 : 0));
    regWrite(4, h%10); regWrite(5, (h/10) | (ignMask[2] ? 8 : 0));
    regWrite(6, w | (ignMask[3] ? 8 : 0));
    regWrite(7, d%10); regWrite(8, (d/10) | (ignMask[4] ? 8 : 0));
  endtask

  task automatic t_reset();
    check("R1 flag", alarmFlag, 0);
    check("R1 enable", irqEnable, 0);
    check("R1 irq", alarmIrq, 0);
  endtask

  task automatic t_basic();
    progAlarm(12, 34, 56, 3, 15, 5'b0);
    setTime(12, 34, 55, 3, 15); tick();
    check("R8 seconds differ", alarmFlag, 0);
    setTime(12, 34, 56, 3, 15); tick();
    check("R4 R2 full match sets flag", alarmFlag, 1);
    check("R6 irq masked by enable", alarmIrq, 0);
  endtask

  task automatic t_sticky();
    setTime(12, 34, 57, 3, 15); tick();
    check("R5 flag held after match ends", alarmFlag, 1);
    regWrite(14, 4'b0010);
    check("R5 write bit1=1 keeps flag", alarmFlag, 1);
    regWrite(14, 4'b0011);
    check("R6 enable set", irqEnable, 1);
    check("R6 irq active", alarmIrq, 1);
    regWrite(14, 4'b0001);
    check("R5 clear flag", alarmFlag, 0);
    check("R6 irq drops", alarmIrq, 0);
    check("R6 enable kept", irqEnable, 1);
  endtask

  task automatic t_edge();
    setTime(12, 34, 56, 3, 15); tick();
    check("R4 new match sets", alarmFlag, 1);
    regWrite(14, 4'b0001);
    tick();
    check("R4 persistent match no re-set", alarmFlag, 0);
    setTime(12, 34, 58, 3, 15); tick();
    setTime(12, 34, 56, 3, 15); tick();
    check("R4 re-armed match sets", alarmFlag, 1);
    check("R6 irq follows", alarmIrq, 1);
  endtask

  task automatic t_setWins();
    setTime(12, 34, 59, 3, 15); tick();
    setTime(12, 34, 56, 3, 15);
    @(negedge clk);
    evalTick = 1'b1; wrEn = 1'b1; wrAddr = 4'd14; wrData = 4'b0000;
    @(negedge clk);
    evalTick = 1'b0; wrEn = 1'b0;
    check("R7 set beats clear", alarmFlag, 1);
    check("R7 enable cleared", irqEnable, 0);
    check("R7 irq off", alarmIrq, 0);
  endtask

  task automatic t_mismatch();
    regWrite(14, 4'b0000);
    setTime(12, 34, 56, 4, 15); tick();
    check("R8 day of week differs", alarmFlag, 0);
    setTime(12, 34, 56, 3, 25); tick();
    check("R8 day tens differs", alarmFlag, 0);
    setTime(13, 34, 56, 3, 15); tick();
    check("R8 hour units differs", alarmFlag, 0);
  endtask

  task automatic t_ignore();
    progAlarm(0, 0, 0, 0, 0, 5'b11110);
    setTime(7, 41, 1, 5, 28); tick();
    check("R3 seconds still compared", alarmFlag, 0);
    setTime(7, 41, 0, 5, 28); tick();
    check("R3 excluded fields match any value", alarmFlag, 1);
    regWrite(14, 4'b0000);
  endtask

  task automatic t_decode();
    progAlarm(12, 34, 56, 3, 15, 5'b0);
    regWrite(14, 4'b0001);
    for (int a = 9; a < 14; a++) regWrite(a, 4'hF);
    regWrite(15, 4'h0);
    check("R2 addr 15 leaves enable", irqEnable, 1);
    check("R2 addr 15 leaves flag", alarmFlag, 0);
    setTime(12, 34, 56, 3, 16); tick();
    check("R2 unmapped writes excluded nothing", alarmFlag, 0);
    setTime(12, 34, 56, 3, 15); tick();
    check("R2 alarm digits intact", alarmFlag, 1);
    check("R6 irq on", alarmIrq, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sticky();
    t_edge();
    t_setWins();
    t_mismatch();
    t_ignore();
    t_decode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule